// File: doc/BRIEF.md
# Shared-Counter PWM Timer

This block is a register-mapped timer in which one prescaled up-counter serves several edge-aligned PWM channels. Software writes a divider and a run mode into a control register, a period limit into a modulo register, and a threshold into each channel's compare register. Every channel drives one output pin, which is high or low depending on whether the shared count is still below that channel's threshold. The counter climbs from zero to the modulo value and then returns to zero. That return marks the start of a new period.

The counter has two states. In STOPPED it holds its value. In RUNNING it advances once per prescaled tick. A control write with the run mode moves STOPPED to RUNNING (transition START). A control write with any other mode moves RUNNING back to STOPPED (transition HALT). While the counter is stopped, modulo and compare writes land at once. While it runs they wait in a buffer until the next period start, so a period never mixes old and new limits. Each channel's mode and polarity bits decode to one of three channel modes: OFF, HIGH_TRUE or LOW_TRUE. They act on the pin right away and are not buffered.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset the count (0x14) reads 0, the modulo (0x18) reads 0xFFFF, and the control register (0x10) reads 0. Every channel register reads 0 and every pin is low.
- R2: Control register 0x10 holds a divider exponent in bits 2:0 and a run mode in bits 4:3. Mode 01 advances the count once every 2^exponent clocks. Modes 00, 10 and 11 leave the count stopped.
- R3: While stopped, the count keeps its value.
- R4: While running, the count goes from 0 up to the modulo value and then returns to 0. A write of any data to 0x14 sets the count to 0.
- R5: While stopped, a write to the modulo (0x18) or to a channel compare register (0x24+8n) takes effect at once and reads back at once.
- R6: While running, modulo and compare writes are held back. Both the readback and the pin behaviour keep the old value until the next return to zero, and the new value is used from then on.
- R7: Channel control register 0x20+8n: bit 5 selects edge PWM and bits 3:2 select polarity. With bit 5 set, 10 drives the pin high while count < compare and low otherwise, and 01 drives the complement.
- R8: With bit 5 clear, or with bits 3:2 equal to 00 or 11, the pin is held low. Any change to the channel control bits reaches the pin on the next cycle, without waiting for a period start.
- R9: In the 10 polarity, a compare of 0 keeps the pin low, and a compare above the modulo keeps it high.
- R10: Channel control bit 7 is a match flag. It sets when a counter tick occurs while the count equals the channel compare. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged.
- R11: Offset 0x04 bits 7:0 read the channel count. Offset 0x08, control bit 5 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| pwm_out | output | NUM_CH (4) | One PWM pin per channel |

## Verification
The embedded properties watch several rules on every cycle:
- the count steps by one or returns to zero on each tick and is frozen while stopped;
- the active modulo and compare values change only at a period start while running, and load at once while stopped;
- the prescaled tick never fires on two consecutive cycles for a nonzero exponent;
- the match flag stays set until a write clears it;
- the pin stays low for a zero compare in the 10 polarity.

Only the bench's scenarios show the remaining behaviours. These are the exact tick rate for a given exponent, the period length after a buffered modulo change, the readback of the new value after the boundary, the immediate effect of polarity writes on the pin, and the decoding of the register offsets.

// File: rtl/spt_pkg.sv
package spt_pkg;

    // Register byte offsets; software decodes these positions.
    localparam int OFS_PARAM  = 'h04;
    localparam int OFS_GLOBAL = 'h08;
    localparam int OFS_CTRL   = 'h10;
    localparam int OFS_COUNT  = 'h14;
    localparam int OFS_MODULO = 'h18;
    localparam int OFS_CH0    = 'h20;
    localparam int CH_STRIDE  = 8;
    localparam int CH_CMP_OFS = 4;

    // Control register field layout.
    localparam int PS_W     = 3;
    localparam int CMOD_LSB = 3;
    localparam logic [1:0] CMOD_RUN = 2'b01;

    // Channel control register bit positions.
    localparam int CH_FLAG_BIT = 7;
    localparam int CH_EDGE_BIT = 5;
    localparam int CH_AUX_BIT  = 4;
    localparam int CH_POL_LSB  = 2;

    typedef enum logic [0:0] {
        CNT_STOP = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef enum logic [1:0] {
        CH_OFF        = 2'd0,
        CH_HIGH_TRUE  = 2'd1,
        CH_LOW_TRUE   = 2'd2
    } ch_mode_e;

endpackage

// File: rtl/spt_prescaler.sv
module spt_prescaler
    import spt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);

    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W:0]   limit;

    always_comb begin
        limit = ((PC_W+1)'(1) << ps) - (PC_W+1)'(1);
    end

    assign tick = run && ({1'b0, pc_q} == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (!run || restart || tick) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

    // R2: with a nonzero exponent two ticks never fall on adjacent cycles
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps != '0) |=> (!tick || ps == '0));

endmodule

// File: rtl/spt_counter.sv
module spt_counter
    import spt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [1:0]       ctl_cmod,
    input  logic             tick,
    input  logic             cnt_clear,
    input  logic             mod_we,
    input  logic [CNT_W-1:0] mod_wdata,
    output logic             run,
    output logic             period_start,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] mod_act
);

    cnt_state_e st_q, st_d;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] mod_act_q;
    logic [CNT_W-1:0] mod_buf_q;
    logic             mod_pend_q;
    logic             wrap;

    // Next-state logic: START on a run-mode write, HALT on any other mode.
    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            unique case (st_q)
                CNT_STOP: if (ctl_cmod == CMOD_RUN) st_d = CNT_RUN;
                CNT_RUN:  if (ctl_cmod != CMOD_RUN) st_d = CNT_STOP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_STOP;
        else        st_q <= st_d;
    end

    assign run  = (st_q == CNT_RUN);
    assign wrap = tick && (count_q >= mod_act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_clear || wrap) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // Modulo double buffer: direct when stopped, deferred when running.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_buf_q  <= '1;
            mod_act_q  <= '1;
            mod_pend_q <= 1'b0;
        end else begin
            if (mod_we) mod_buf_q <= mod_wdata;

            if (mod_we && !run) mod_act_q <= mod_wdata;
            else if (wrap && mod_pend_q) mod_act_q <= mod_buf_q;

            if (mod_we) mod_pend_q <= run;
            else if (wrap) mod_pend_q <= 1'b0;
        end
    end

    assign period_start = wrap;
    assign count        = count_q;
    assign mod_act      = mod_act_q;

    // R3: a stopped counter keeps its value unless cleared
    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_clear) |=> $stable(count_q));

    // R4: reaching the modulo on a tick returns the count to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q >= mod_act_q) |=> (count_q == '0));

    // R4: below the modulo each tick adds exactly one
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q < mod_act_q && !cnt_clear) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R5: a modulo write while stopped is active on the next cycle
    a_r5_mod_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_we && !run) |=> (mod_act_q == $past(mod_wdata)));

    // R6: while running the active modulo only moves at a period start
    a_r6_mod_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(mod_act_q));

endmodule

// File: rtl/spt_channel.sv
module spt_channel
    import spt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             period_start,
    input  logic [CNT_W-1:0] count,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [7:0]       ctl_rd,
    output logic [CNT_W-1:0] cmp_rd,
    output logic             pwm
);

    logic             flag_q;
    logic             edge_q;
    logic             aux_q;
    logic [1:0]       pol_q;
    logic [CNT_W-1:0] cmp_act_q;
    logic [CNT_W-1:0] cmp_buf_q;
    logic             cmp_pend_q;
    logic             below;
    logic             match_tick;
    ch_mode_e         mode;

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl_wdata[6], ctl_wdata[1:0]};

    // Mode and polarity bits: immediate, no period buffering.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
            aux_q  <= 1'b0;
            pol_q  <= 2'b00;
        end else if (ctl_we) begin
            edge_q <= ctl_wdata[CH_EDGE_BIT];
            aux_q  <= ctl_wdata[CH_AUX_BIT];
            pol_q  <= ctl_wdata[CH_POL_LSB +: 2];
        end
    end

    assign match_tick = tick && (count == cmp_act_q);

    // Match flag: set wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match_tick) begin
            flag_q <= 1'b1;
        end else if (ctl_we && ctl_wdata[CH_FLAG_BIT]) begin
            flag_q <= 1'b0;
        end
    end

    // Compare double buffer, same discipline as the modulo.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_buf_q  <= '0;
            cmp_act_q  <= '0;
            cmp_pend_q <= 1'b0;
        end else begin
            if (cmp_we) cmp_buf_q <= cmp_wdata;

            if (cmp_we && !run) cmp_act_q <= cmp_wdata;
            else if (period_start && cmp_pend_q) cmp_act_q <= cmp_buf_q;

            if (cmp_we) cmp_pend_q <= run;
            else if (period_start) cmp_pend_q <= 1'b0;
        end
    end

    always_comb begin
        if (!edge_q) begin
            mode = CH_OFF;
        end else begin
            unique case (pol_q)
                2'b10:   mode = CH_HIGH_TRUE;
                2'b01:   mode = CH_LOW_TRUE;
                default: mode = CH_OFF;
            endcase
        end
    end

    assign below = (count < cmp_act_q);

    always_comb begin
        unique case (mode)
            CH_HIGH_TRUE: pwm = below;
            CH_LOW_TRUE:  pwm = !below;
            default:      pwm = 1'b0;
        endcase
    end

    assign ctl_rd = {flag_q, 1'b0, edge_q, aux_q, pol_q, 2'b00};
    assign cmp_rd = cmp_act_q;

    // R10: a tick on a matching count raises the flag
    a_r10_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        match_tick |=> flag_q);

    // R10: the flag stays set until a one is written to it
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(ctl_we && ctl_wdata[CH_FLAG_BIT])) |=> flag_q);

    // R9: a zero compare keeps a high-true channel low
    a_r9_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CH_HIGH_TRUE && cmp_act_q == '0) |-> !pwm);

    // R5: a compare write while stopped is active on the next cycle
    a_r5_cmp_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && !run) |=> (cmp_act_q == $past(cmp_wdata)));

    // R6: while running the active compare only moves at a period start
    a_r6_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !period_start) |=> $stable(cmp_act_q));

endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
    import spt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam logic [ADDR_W-1:0] A_PARAM  = ADDR_W'(OFS_PARAM);
    localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(OFS_GLOBAL);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_MODULO = ADDR_W'(OFS_MODULO);

    function automatic logic [ADDR_W-1:0] ch_ctl_addr(input int idx);
        return ADDR_W'(OFS_CH0 + idx * CH_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] ch_cmp_addr(input int idx);
        return ADDR_W'(OFS_CH0 + idx * CH_STRIDE + CH_CMP_OFS);
    endfunction

    logic [PS_W-1:0]  ps_q;
    logic [1:0]       cmod_q;
    logic             ctl_we;
    logic             cnt_clear;
    logic             mod_we;
    logic             run;
    logic             tick;
    logic             period_start;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] mod_act;

    logic [7:0]       ch_ctl_rd [NUM_CH];
    logic [CNT_W-1:0] ch_cmp_rd [NUM_CH];

    logic unused_wr_hi;
    assign unused_wr_hi = ^bus_wdata[DATA_W-1:CNT_W];

    assign ctl_we    = bus_we && (bus_addr == A_CTRL);
    assign cnt_clear = bus_we && (bus_addr == A_COUNT);
    assign mod_we    = bus_we && (bus_addr == A_MODULO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q   <= '0;
            cmod_q <= 2'b00;
        end else if (ctl_we) begin
            ps_q   <= bus_wdata[PS_W-1:0];
            cmod_q <= bus_wdata[CMOD_LSB +: 2];
        end
    end

    spt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_we       (ctl_we),
        .ctl_cmod     (bus_wdata[CMOD_LSB +: 2]),
        .tick         (tick),
        .cnt_clear    (cnt_clear),
        .mod_we       (mod_we),
        .mod_wdata    (bus_wdata[CNT_W-1:0]),
        .run          (run),
        .period_start (period_start),
        .count        (count),
        .mod_act      (mod_act)
    );

    spt_prescaler u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (cnt_clear),
        .ps      (ps_q),
        .tick    (tick)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic ch_ctl_we;
        logic ch_cmp_we;

        assign ch_ctl_we = bus_we && (bus_addr == ch_ctl_addr(gi));
        assign ch_cmp_we = bus_we && (bus_addr == ch_cmp_addr(gi));

        spt_channel #(.CNT_W(CNT_W)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .run          (run),
            .tick         (tick),
            .period_start (period_start),
            .count        (count),
            .ctl_we       (ch_ctl_we),
            .ctl_wdata    (bus_wdata[7:0]),
            .cmp_we       (ch_cmp_we),
            .cmp_wdata    (bus_wdata[CNT_W-1:0]),
            .ctl_rd       (ch_ctl_rd[gi]),
            .cmp_rd       (ch_cmp_rd[gi]),
            .pwm          (pwm_out[gi])
        );
    end

    // Read multiplexer; unmapped offsets and the global word read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_PARAM) begin
            bus_rdata[7:0] = 8'(NUM_CH);
        end else if (bus_addr == A_GLOBAL) begin
            bus_rdata = '0;
        end else if (bus_addr == A_CTRL) begin
            bus_rdata[PS_W-1:0]       = ps_q;
            bus_rdata[CMOD_LSB +: 2]  = cmod_q;
        end else if (bus_addr == A_COUNT) begin
            bus_rdata[CNT_W-1:0] = count;
        end else if (bus_addr == A_MODULO) begin
            bus_rdata[CNT_W-1:0] = mod_act;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ch_ctl_addr(i)) bus_rdata[7:0] = ch_ctl_rd[i];
                if (bus_addr == ch_cmp_addr(i)) bus_rdata[CNT_W-1:0] = ch_cmp_rd[i];
            end
        end
    end

    // R2: the counter only leaves zero-progress when the run mode is stored
    a_r2_run_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cmod_q != CMOD_RUN) |-> !tick);

endmodule

// File: tb/shared_pwm_timer_tb.sv
module shared_pwm_timer_tb;

    localparam int NUM_CH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        bit          is_pin;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     mon_ev;

    always #10 clk = ~clk;

    shared_pwm_timer #(.NUM_CH(NUM_CH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // Monitor: pops expected items and compares them with the design.
    initial begin
        forever begin
            @(mon_ev);
            #2;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_pin ? 32'(pwm_out[it.sel]) : bus_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb_q.push_back('{1'b0, int'(a), e, tag});
        ->mon_ev;
        #5;
    endtask

    task automatic chk_pin(input int ch, input logic e, input string tag);
        @(negedge clk);
        sb_q.push_back('{1'b1, ch, 32'(e), tag});
        ->mon_ev;
        #5;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd(8'h14, 32'h0, "R1 count");
        chk_rd(8'h18, 32'hFFFF, "R1 modulo");
        chk_rd(8'h10, 32'h0, "R1 control");
        chk_rd(8'h20, 32'h0, "R1 ch0 ctl");
        chk_rd(8'h24, 32'h0, "R1 ch0 cmp");
        for (int i = 0; i < NUM_CH; i++) chk_pin(i, 1'b0, "R1 pin low");

        // R11 identification and zero reads
        chk_rd(8'h04, 32'd4, "R11 channel count");
        chk_rd(8'h08, 32'h0, "R11 global reads zero");
        chk_rd(8'h40, 32'h0, "R11 unmapped reads zero");

        // R5 direct loads while stopped
        wr(8'h18, 32'd9);
        chk_rd(8'h18, 32'd9, "R5 modulo direct");
        wr(8'h24, 32'd3);
        chk_rd(8'h24, 32'd3, "R5 compare direct");

        // R7 / R8 / R9 pin decoding at count 0
        wr(8'h20, 32'h28);
        chk_pin(0, 1'b1, "R7 high-true below compare");
        wr(8'h20, 32'h2C);
        chk_pin(0, 1'b0, "R8 reserved polarity 11");
        wr(8'h20, 32'h08);
        chk_pin(0, 1'b0, "R8 edge bit clear");
        wr(8'h20, 32'h24);
        chk_pin(0, 1'b0, "R7 low-true below compare");
        wr(8'h24, 32'd0);
        chk_pin(0, 1'b1, "R7 low-true at compare");
        wr(8'h20, 32'h28);
        chk_pin(0, 1'b0, "R9 compare zero low");
        wr(8'h24, 32'd10);
        chk_pin(0, 1'b1, "R9 compare above modulo high");

        // R2 divide by 4: 20 running edges give 5 ticks
        wr(8'h10, 32'h0A);
        repeat (18) @(negedge clk);
        wr(8'h10, 32'h02);
        chk_rd(8'h14, 32'd5, "R2 prescaled count");
        chk_rd(8'h10, 32'h02, "R2 control readback");
        chk_pin(0, 1'b1, "R9 above modulo at count 5");
        repeat (5) @(negedge clk);
        chk_rd(8'h14, 32'd5, "R3 stopped holds");

        // R4 clear and wrap
        wr(8'h14, 32'h1234);
        chk_rd(8'h14, 32'h0, "R4 count write clears");
        wr(8'h18, 32'd4);
        wr(8'h10, 32'h08);
        repeat (10) @(negedge clk);
        wr(8'h10, 32'h00);
        chk_rd(8'h14, 32'd2, "R4 wrap after 12 ticks mod 4");

        // R2 mode 11 stops, R11 bit 5 reads zero
        wr(8'h10, 32'h3A);
        chk_rd(8'h10, 32'h1A, "R11 control bit5 reads zero");
        repeat (4) @(negedge clk);
        chk_rd(8'h14, 32'd2, "R2 mode 11 stopped");
        wr(8'h10, 32'h00);

        // R6 buffered modulo
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h08);
        wr(8'h18, 32'd9);
        chk_rd(8'h18, 32'd4, "R6 modulo held before wrap");
        repeat (6) @(negedge clk);
        chk_rd(8'h18, 32'd9, "R6 modulo loaded at wrap");
        wr(8'h10, 32'h00);
        chk_rd(8'h14, 32'd7, "R6 new period length");

        // R6 buffered compare, R8 immediate polarity
        wr(8'h14, 32'h0);
        wr(8'h24, 32'd10);
        wr(8'h20, 32'h28);
        wr(8'h10, 32'h08);
        chk_pin(0, 1'b1, "R6 pin before compare write");
        wr(8'h24, 32'd0);
        chk_rd(8'h24, 32'd10, "R6 compare held before wrap");
        chk_pin(0, 1'b1, "R6 pin uses old compare");
        repeat (12) @(negedge clk);
        chk_rd(8'h24, 32'd0, "R6 compare loaded at wrap");
        chk_pin(0, 1'b0, "R6 pin uses new compare");
        wr(8'h20, 32'h24);
        chk_pin(0, 1'b1, "R8 polarity change immediate");
        wr(8'h10, 32'h00);

        // R10 match flag
        wr(8'h14, 32'h0);
        wr(8'h2C, 32'd2);
        wr(8'h28, 32'hA8);
        chk_rd(8'h28, 32'h28, "R10 write one clears flag");
        wr(8'h10, 32'h08);
        repeat (3) @(negedge clk);
        wr(8'h10, 32'h00);
        chk_rd(8'h28, 32'hA8, "R10 flag set on match");
        chk_pin(1, 1'b0, "R7 ch1 count above compare");
        wr(8'h28, 32'h28);
        chk_rd(8'h28, 32'hA8, "R10 write zero keeps flag");
        wr(8'h28, 32'hA8);
        chk_rd(8'h28, 32'h28, "R10 flag cleared");

        #40;
        done = 1;
        finish_run();
    end

endmodule